// File: doc/BRIEF.md
# Attack-Map Capture Sequencer

This block builds the capture list for one side of a chess position from an attack map held in memory. Each map word covers one board square and records which pieces of the side to move attack that square. When a pass starts, the sequencer steps through a victim list supplied on its inputs. Entry 0 is the opponent's most valuable piece and the last entry its least valuable one, so captures come out most-valuable-victim first. The sequencer skips list entries marked empty. For each remaining victim it reads one map word, then removes the set bits one per clock and emits one capture record per bit.

A map word has two bytes. The low byte holds short-range attackers: bits 0 and 1 are pawns, bits 2 and 3 are knights, and bit 4 is the king. The high byte holds line-moving attackers: bits 0 and 1 are bishops, bits 2 and 3 are rooks, and bit 4 is the queen. The sequencer drains the low byte before the high byte, lowest bit first, which roughly orders captures least-valuable attacker first. The identity of an attacking piece is looked up outside the block, and only for bits that are actually set. The map may hold attacks on the side's own pieces, but those squares never appear as victims, because the list names only opponent pieces. Captures leave the block on a valid/ready stream, and a single-cycle done pulse ends the pass.

Top module: `capture_seq`

## Requirements
- R1: While reset is held and right after it, cap_valid_o, done_o, map_rd_en_o and lut_req_o are all 0.
- R2: Victims are visited in ascending list index, starting at 0. An entry whose vic_vld_i bit is 0 gets no map read and produces no records. Records of a lower index always come out before those of a higher index.
- R3: Each valid victim gets exactly one read: map_rd_en_o is high for one cycle with map_rd_addr_o equal to that victim's square. The data on map_rd_data_i is used in the cycle after the request. Bits [7:0] are the short-range byte and bits [15:8] the line-moving byte.
- R4: One record is produced for each set bit of the word, including bits 5 to 7 of either byte. An all-zero word produces no record.
- R5: Within one victim, all records from the short-range byte (cap_slider_o=0) come before those from the line-moving byte (cap_slider_o=1). Within a byte, records come in ascending bit index, carried on cap_bit_o. cap_vic_o carries the victim's list index.
- R6: lut_req_o is high exactly in the cycles when a record enters the output stage. In those cycles lut_sq_o, lut_slider_o and lut_bit_o describe that record, and the value of lut_piece_i is stored as cap_piece_o.
- R7: While cap_valid_o is high and cap_ready_i is low, the record stays valid and unchanged. No record is lost or repeated.
- R8: done_o is high for exactly one cycle per pass. It comes after the last record has been accepted and while cap_valid_o is 0, and it also comes for a pass that produces no records.
- R9: start_i is ignored while a pass is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a pass (taken only when idle) |
| vic_sq_i | input | NV*SQ_W | Victim squares, entry i at bits [i*SQ_W +: SQ_W] |
| vic_vld_i | input | NV | Victim entry present flags |
| map_rd_en_o | output | 1 | Attack-map read request |
| map_rd_addr_o | output | SQ_W | Square to read |
| map_rd_data_i | input | 2*BYTE_W | Map word, one cycle after request |
| lut_req_o | output | 1 | Attacker lookup in use |
| lut_sq_o | output | SQ_W | Victim square for the lookup |
| lut_slider_o | output | 1 | Byte of the bit being decoded |
| lut_bit_o | output | BIT_W | Bit index being decoded |
| lut_piece_i | input | PC_W | Attacking piece identity |
| cap_valid_o | output | 1 | Capture record valid |
| cap_ready_i | input | 1 | Consumer accepts record |
| cap_vic_o | output | VIC_W | Victim list index |
| cap_slider_o | output | 1 | 1 when the attacker is from the line-moving byte |
| cap_bit_o | output | BIT_W | Attacker bit index within its byte |
| cap_piece_o | output | PC_W | Attacker identity from lookup |
| done_o | output | 1 | Pass finished pulse |

## Verification
The assertions assume that the victim list and the attack map stay unchanged from start_i until done_o, and that the map answers a read with valid data in the following cycle. The bench meets this by loading a new victim list and map contents only between passes. It serves reads from its own memory model and answers the lookup with a pure function of its request lines. The ready signal is randomized at several acceptance rates. Extra start pulses are issued in the middle of a pass to show that start_i has no effect while a pass is running.

// File: rtl/capseq_pkg.sv
// Shared types for the capture sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package capseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FETCH,
        ST_LOAD,
        ST_DRAIN,
        ST_FLUSH,
        ST_DONE
    } seq_st_e;
endpackage

// File: rtl/capseq_bitpick.sv
// Lowest-set-bit picker: isolates the lowest 1 of a vector (x & -x),
// encodes its position and returns the vector with that bit cleared
// (x & (x-1)). Purely combinational; assumes W >= 2.
module capseq_bitpick #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  rest_o
);
    logic [W-1:0] iso;

    // isolate lowest set bit and clear it
    always_comb begin
        iso    = vec_i & (~vec_i + W'(1));
        rest_o = vec_i & (vec_i - W'(1));
        any_o  = |vec_i;
    end

    // encode the one-hot position of the isolated bit
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (iso[i]) idx_o = idx_o | IW'(i);
        end
    end
endmodule

// File: rtl/capseq_vicsel.sv
// Victim selector: returns the square and present flag of list entry
// idx_i and flags the final entry. Assumes idx_i < NV.
module capseq_vicsel #(
    parameter int NV   = 16,
    parameter int SQ_W = 7,
    localparam int VIC_W = $clog2(NV)
) (
    input  logic [NV*SQ_W-1:0] sq_i,
    input  logic [NV-1:0]      vld_i,
    input  logic [VIC_W-1:0]   idx_i,
    output logic [SQ_W-1:0]    sq_o,
    output logic               vld_o,
    output logic               last_o
);
    // pick the indexed entry
    always_comb begin
        sq_o   = sq_i[idx_i*SQ_W +: SQ_W];
        vld_o  = vld_i[idx_i];
        last_o = (idx_i == VIC_W'(NV - 1));
    end
endmodule

// File: rtl/capseq_outreg.sv
// Single-entry output stage for a valid/ready stream. Accepts a new
// word whenever it is empty or its word leaves in the same cycle;
// holds the word steady under back-pressure. Assumes load_i is only
// raised when free_o is high.
module capseq_outreg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    input  logic          ready_i,
    output logic          free_o,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);
    // stage can take a word this cycle
    always_comb free_o = !valid_o || ready_i;

    // hold or replace the stored word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            data_o  <= data_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/capture_seq.sv
// Capture sequencer top. Walks the victim list in index order, reads
// one attack-map word per present victim, drains the short-range byte
// then the line-moving byte one set bit per cycle, looks up each
// attacker and streams (victim, attacker) records, then pulses done.
// Assumes vic_* and the map are stable during a pass and that the map
// returns data in the cycle after a read request.
module capture_seq #(
    parameter int NV     = 16,
    parameter int SQ_W   = 7,
    parameter int BYTE_W = 8,
    parameter int PC_W   = 5,
    localparam int VIC_W = $clog2(NV),
    localparam int BIT_W = $clog2(BYTE_W),
    localparam int REC_W = VIC_W + 1 + BIT_W + PC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NV*SQ_W-1:0]   vic_sq_i,
    input  logic [NV-1:0]        vic_vld_i,
    output logic                 map_rd_en_o,
    output logic [SQ_W-1:0]      map_rd_addr_o,
    input  logic [2*BYTE_W-1:0]  map_rd_data_i,
    output logic                 lut_req_o,
    output logic [SQ_W-1:0]      lut_sq_o,
    output logic                 lut_slider_o,
    output logic [BIT_W-1:0]     lut_bit_o,
    input  logic [PC_W-1:0]      lut_piece_i,
    output logic                 cap_valid_o,
    input  logic                 cap_ready_i,
    output logic [VIC_W-1:0]     cap_vic_o,
    output logic                 cap_slider_o,
    output logic [BIT_W-1:0]     cap_bit_o,
    output logic [PC_W-1:0]      cap_piece_o,
    output logic                 done_o
);
    import capseq_pkg::*;

    seq_st_e             st_q;
    logic [VIC_W-1:0]    idx_q;
    logic [SQ_W-1:0]     cur_sq;
    logic                cur_vld;
    logic                cur_last;

    // index 0 = short-range byte, index 1 = line-moving byte
    logic [BYTE_W-1:0]   pend_q [2];
    logic [BYTE_W-1:0]   pend_rest [2];
    logic [BIT_W-1:0]    pend_idx [2];
    logic                pend_any [2];

    logic                use_hi;
    logic                emit;
    logic                free;
    logic [REC_W-1:0]    rec_d;
    logic [REC_W-1:0]    rec_q;

    capseq_vicsel #(.NV(NV), .SQ_W(SQ_W)) u_vsel (
        .sq_i   (vic_sq_i),
        .vld_i  (vic_vld_i),
        .idx_i  (idx_q),
        .sq_o   (cur_sq),
        .vld_o  (cur_vld),
        .last_o (cur_last)
    );

    // one lowest-bit picker per attack byte
    for (genvar b = 0; b < 2; b++) begin : g_pick
        capseq_bitpick #(.W(BYTE_W)) u_pick (
            .vec_i  (pend_q[b]),
            .any_o  (pend_any[b]),
            .idx_o  (pend_idx[b]),
            .rest_o (pend_rest[b])
        );
    end

    // choose the byte to drain and whether a record leaves this cycle
    always_comb begin
        use_hi       = !pend_any[0];
        emit         = (st_q == ST_DRAIN) && (pend_any[0] || pend_any[1]) && free;
        lut_req_o    = emit;
        lut_sq_o     = cur_sq;
        lut_slider_o = use_hi;
        lut_bit_o    = use_hi ? pend_idx[1] : pend_idx[0];
        rec_d        = {idx_q, use_hi, lut_bit_o, lut_piece_i};
    end

    // map read request for the current victim
    always_comb begin
        map_rd_en_o   = (st_q == ST_FETCH);
        map_rd_addr_o = cur_sq;
        done_o        = (st_q == ST_DONE);
    end

    // pass control: victim walk, map load and bit drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            idx_q     <= '0;
            pend_q[0] <= '0;
            pend_q[1] <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        idx_q <= '0;
                        st_q  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (cur_vld)       st_q <= ST_FETCH;
                    else if (cur_last) st_q <= ST_FLUSH;
                    else               idx_q <= idx_q + VIC_W'(1);
                end
                ST_FETCH: st_q <= ST_LOAD;
                ST_LOAD: begin
                    pend_q[0] <= map_rd_data_i[BYTE_W-1:0];
                    pend_q[1] <= map_rd_data_i[2*BYTE_W-1:BYTE_W];
                    st_q      <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!pend_any[0] && !pend_any[1]) begin
                        if (cur_last) begin
                            st_q <= ST_FLUSH;
                        end else begin
                            idx_q <= idx_q + VIC_W'(1);
                            st_q  <= ST_SCAN;
                        end
                    end else if (emit) begin
                        if (use_hi) pend_q[1] <= pend_rest[1];
                        else        pend_q[0] <= pend_rest[0];
                    end
                end
                ST_FLUSH: begin
                    if (!cap_valid_o) st_q <= ST_DONE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    capseq_outreg #(.DW(REC_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (emit),
        .data_i  (rec_d),
        .ready_i (cap_ready_i),
        .free_o  (free),
        .valid_o (cap_valid_o),
        .data_o  (rec_q)
    );

    // unpack the stored record
    always_comb {cap_vic_o, cap_slider_o, cap_bit_o, cap_piece_o} = rec_q;
endmodule

// File: rtl/capseq_chk.sv
// Assertion checker for capture_seq, bound to every instance.
// Assumes victim list and map are stable during a pass.
module capseq_chk #(
    parameter int VIC_W = 4,
    parameter int BIT_W = 3,
    parameter int PC_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_valid_o,
    input logic             cap_ready_i,
    input logic [VIC_W-1:0] cap_vic_o,
    input logic             cap_slider_o,
    input logic [BIT_W-1:0] cap_bit_o,
    input logic [PC_W-1:0]  cap_piece_o,
    input logic             done_o,
    input logic             map_rd_en_o,
    input logic             lut_req_o
);
    logic             have_prev;
    logic [VIC_W-1:0] prev_vic;
    logic [BIT_W:0]   prev_key;
    logic             acc;

    always_comb acc = cap_valid_o && cap_ready_i;

    // remember the last accepted record of the current pass
    always_ff @(posedge clk) begin
        if (!rst_n || done_o) begin
            have_prev <= 1'b0;
            prev_vic  <= '0;
            prev_key  <= '0;
        end else if (acc) begin
            have_prev <= 1'b1;
            prev_vic  <= cap_vic_o;
            prev_key  <= {cap_slider_o, cap_bit_o};
        end
    end

    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> !cap_valid_o && !done_o && !map_rd_en_o);

    a_r7_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_o && !cap_ready_i |=>
            cap_valid_o && $stable({cap_vic_o, cap_slider_o, cap_bit_o, cap_piece_o}));

    a_r8_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cap_valid_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r3_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd_en_o |=> !map_rd_en_o);

    a_r6_lut_loads: assert property (@(posedge clk) disable iff (!rst_n)
        lut_req_o |=> cap_valid_o);

    a_r6_lut_free: assert property (@(posedge clk) disable iff (!rst_n)
        lut_req_o |-> (!cap_valid_o || cap_ready_i));

    a_r2_victim_order: assert property (@(posedge clk) disable iff (!rst_n)
        acc && have_prev |-> cap_vic_o >= prev_vic);

    a_r5_attacker_order: assert property (@(posedge clk) disable iff (!rst_n)
        acc && have_prev && cap_vic_o == prev_vic |->
            {cap_slider_o, cap_bit_o} > prev_key);
endmodule

bind capture_seq capseq_chk #(.VIC_W(VIC_W), .BIT_W(BIT_W), .PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_valid_o  (cap_valid_o),
    .cap_ready_i  (cap_ready_i),
    .cap_vic_o    (cap_vic_o),
    .cap_slider_o (cap_slider_o),
    .cap_bit_o    (cap_bit_o),
    .cap_piece_o  (cap_piece_o),
    .done_o       (done_o),
    .map_rd_en_o  (map_rd_en_o),
    .lut_req_o    (lut_req_o)
);

// File: tb/sim_capture_seq.sv
// Bench for capture_seq: memory model, lookup model and expected
// capture lists computed from the requirements.
module sim_capture_seq;
    localparam int NV = 16, SQ_W = 7, BYTE_W = 8, PC_W = 5;
    localparam int VIC_W = 4, BIT_W = 3;
    localparam int MAXR = 512;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [NV*SQ_W-1:0] vsq = '0;
    logic [NV-1:0] vvld = '0;
    logic rd_en, lut_req, lut_sl, cap_valid, cap_sl, done;
    logic [SQ_W-1:0] rd_addr, lut_sq;
    logic [2*BYTE_W-1:0] rd_data = '0;
    logic [BIT_W-1:0] lut_bit, cap_bit;
    logic [PC_W-1:0] lut_piece, cap_piece;
    logic [VIC_W-1:0] cap_vic;
    logic rdy = 1'b0;

    logic [2*BYTE_W-1:0] mem [128];
    int exp_vic [MAXR];
    int exp_sl [MAXR];
    int exp_bit [MAXR];
    int exp_pc [MAXR];
    int exp_rd [NV];
    int n_exp, n_rd;
    int checks = 0, errors = 0;
    int cycles = 0;
    bit hung = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [PC_W-1:0] lut_fn(logic [SQ_W-1:0] sq, logic sl, logic [BIT_W-1:0] b);
        return PC_W'(int'(sq) * 3 + int'({sl, b}));
    endfunction

    assign lut_piece = lut_fn(lut_sq, lut_sl, lut_bit);

    capture_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .vic_sq_i(vsq), .vic_vld_i(vvld),
        .map_rd_en_o(rd_en), .map_rd_addr_o(rd_addr), .map_rd_data_i(rd_data),
        .lut_req_o(lut_req), .lut_sq_o(lut_sq), .lut_slider_o(lut_sl),
        .lut_bit_o(lut_bit), .lut_piece_i(lut_piece),
        .cap_valid_o(cap_valid), .cap_ready_i(rdy), .cap_vic_o(cap_vic),
        .cap_slider_o(cap_sl), .cap_bit_o(cap_bit), .cap_piece_o(cap_piece),
        .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // expected list: ascending victims, low byte then high byte, ascending bits (R2 R4 R5)
    task automatic build_expected();
        n_exp = 0;
        n_rd  = 0;
        for (int v = 0; v < NV; v++) begin
            if (vvld[v]) begin
                logic [SQ_W-1:0] sq;
                logic [2*BYTE_W-1:0] w;
                sq = vsq[v*SQ_W +: SQ_W];
                w  = mem[sq];
                exp_rd[n_rd] = int'(sq);
                n_rd++;
                for (int s = 0; s < 2; s++) begin
                    for (int b = 0; b < BYTE_W; b++) begin
                        if (w[s*BYTE_W + b]) begin
                            exp_vic[n_exp] = v;
                            exp_sl[n_exp]  = s;
                            exp_bit[n_exp] = b;
                            exp_pc[n_exp]  = int'(lut_fn(sq, s[0], BIT_W'(b)));
                            n_exp++;
                        end
                    end
                end
            end
        end
    endtask

    task automatic run_pass(input int pct, input bit restart_mid);
        int k = 0, r = 0, dcnt = 0, pc = 0, after = 0;
        bit held = 1'b0;
        int h_vic = 0, h_sl = 0, h_bit = 0, h_pc = 0;
        build_expected();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (after < 6) begin
            @(negedge clk);
            pc++;
            cycles++;
            if (pc > 20000) begin
                chk(1'b0, "watchdog", pc, 20000);
                hung = 1'b1;
                break;
            end
            start = (restart_mid && pc == 5) ? 1'b1 : 1'b0;   // R9 stray start
            if (rd_en) begin                                  // R3 read address and order
                chk(r < n_rd && int'(rd_addr) == exp_rd[r], "R3 read addr", int'(rd_addr), r < n_rd ? exp_rd[r] : -1);
                r++;
                rd_data = mem[rd_addr];
            end
            if (held) begin                                   // R7 hold under stall
                chk(cap_valid && int'(cap_vic) == h_vic && int'(cap_sl) == h_sl &&
                    int'(cap_bit) == h_bit && int'(cap_piece) == h_pc,
                    "R7 held record", int'(cap_bit), h_bit);
            end
            if (done) begin                                   // R8 done after last accept
                dcnt++;
                chk(k == n_exp && !cap_valid, "R8 done after last record", k, n_exp);
            end
            if (dcnt > 0) after++;
            rdy = ($urandom_range(99) < pct);
            held = cap_valid && !rdy;
            h_vic = int'(cap_vic); h_sl = int'(cap_sl); h_bit = int'(cap_bit); h_pc = int'(cap_piece);
            if (cap_valid && rdy) begin                       // R4 R5 R6 record contents
                if (k < n_exp) begin
                    chk(int'(cap_vic) == exp_vic[k], "R2 victim index", int'(cap_vic), exp_vic[k]);
                    chk(int'(cap_sl) == exp_sl[k] && int'(cap_bit) == exp_bit[k], "R5 attacker order",
                        int'({cap_sl, cap_bit}), exp_sl[k] * 8 + exp_bit[k]);
                    chk(int'(cap_piece) == exp_pc[k], "R6 piece lookup", int'(cap_piece), exp_pc[k]);
                end else begin
                    chk(1'b0, "R4 extra record", k, n_exp);
                end
                k++;
            end
        end
        rdy = 1'b0;
        start = 1'b0;
        chk(k == n_exp, "R4 record count", k, n_exp);
        chk(r == n_rd, "R2 read count", r, n_rd);
        chk(dcnt == 1, restart_mid ? "R9 single done with stray start" : "R8 single done", dcnt, 1);
    endtask

    task automatic rand_setup(input int dens);
        for (int v = 0; v < NV; v++) vsq[v*SQ_W +: SQ_W] = SQ_W'($urandom_range(127));
        vvld = NV'($urandom);
        for (int a = 0; a < 128; a++) begin
            if ($urandom_range(99) < dens) mem[a] = 16'($urandom) & 16'($urandom) & 16'h1F1F;
            else if ($urandom_range(99) < 5) mem[a] = 16'($urandom);
            else mem[a] = '0;
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < 128; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk(!cap_valid && !done && !rd_en && !lut_req, "R1 reset outputs", int'(cap_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cap_valid && !done && !rd_en && !lut_req, "R1 after reset", int'(done), 0);

        // R2 no valid victims: no reads, done only
        vvld = '0;
        run_pass(100, 1'b0);
        // R4 all-zero map: reads but no records
        rand_setup(0);
        vvld = '1;
        for (int a = 0; a < 128; a++) mem[a] = '0;
        run_pass(100, 1'b0);
        // R4 R5 every bit set on one victim, last entry
        vvld = '0;
        vvld[NV-1] = 1'b1;
        vsq[(NV-1)*SQ_W +: SQ_W] = 7'h44;
        mem[7'h44] = 16'hFFFF;
        run_pass(100, 1'b0);
        // R7 heavy back-pressure on the same list
        run_pass(15, 1'b0);
        // R9 stray start during a pass
        rand_setup(60);
        run_pass(70, 1'b1);
        // random passes
        for (int p = 0; p < 30 && !hung; p++) begin
            rand_setup(40);
            run_pass(20 + 25 * (p % 4), p % 5 == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule